// File: doc/BRIEF.md
# Multi-mode integer divide unit

An iterative execution unit that divides two 64-bit register operands and returns only the quotient. It covers four operations: signed or unsigned division, each at word (32-bit) or double-word (64-bit) width. A one-cycle `start` strobe launches an operation. The unit then runs through a fixed state sequence and signals completion with a one-cycle `done` pulse. When a write is due, the pulse carries the quotient, its destination register index and a write enable.

Three cases never enter the quotient loop: a zero divisor, a most-negative over minus-one overflow, and a zero destination index. These are settled in the setup cycle. A double-word operation issued while the core is not in 64-bit mode is refused with an illegal flag. Word results are always sign-extended from bit 31, including unsigned word results.

States: `ST_IDLE` accepts a start and latches the operands. `ST_SETUP` prepares the operands and detects special cases. `ST_ITER` retires one quotient bit per clock. `ST_FINAL` applies the sign and the width extension. `ST_RESP` presents the response.

Transitions:
- IDLE→SETUP on start.
- SETUP→RESP on an illegal operation, a zero destination, a zero divisor or an overflow.
- SETUP→ITER otherwise.
- ITER→ITER until the last bit.
- ITER→FINAL after the last bit.
- FINAL→RESP.
- RESP→IDLE always.

Top module: `qdiv_unit`

## Requirements
- R1: A completed legal operation with a non-zero destination raises `wr_en` together with `done`. At that point `result` holds the quotient and `result_dest` equals the `dest` given at start.
- R2: When `dest` is 0, `done` pulses one cycle after the start edge, `wr_en` stays low, and no quotient iteration runs.
- R3: A divisor equal to zero at the operating width gives a result of 0, in signed and unsigned mode and at both widths.
- R4: In signed mode, the most-negative value divided by −1 returns the dividend. At 64-bit width this is 0x8000_0000_0000_0000. At 32-bit width it is 0xFFFF_FFFF_8000_0000.
- R5: Signed division truncates toward zero. The quotient is negative exactly when the operand signs differ.
- R6: For signed word operations, both operands are sign-extended from bit 31, and register bits 63:32 are ignored.
- R7: For unsigned word operations, both operands are zero-extended from bit 31, and register bits 63:32 are ignored.
- R8: Every word result, signed or unsigned, is written sign-extended from bit 31.
- R9: When `is_dword`=1 and `mode64_en`=0, `illegal` pulses with `done` one cycle after the start edge, and `wr_en` stays low.
- R10: An operation that enters the loop has `done` 34 cycles after the start edge in word mode and 66 cycles after it in double-word mode. That is the width in bits plus 2.
- R11: `start` is ignored while an operation is in progress, and `done` is a single-cycle pulse.
- R12: After reset, `done`, `wr_en` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe, accepted only when idle |
| is_signed | input | 1 | 1 = signed division, 0 = unsigned |
| is_dword | input | 1 | 1 = 64-bit operation, 0 = 32-bit |
| mode64_en | input | 1 | Core runs with 64-bit operations enabled |
| opa | input | 64 | Dividend register value |
| opb | input | 64 | Divisor register value |
| dest | input | 5 | Destination register index |
| result | output | 64 | Quotient, valid while `wr_en` is high |
| result_dest | output | 5 | Destination index of the response |
| wr_en | output | 1 | Register write request, coincident with `done` |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Double-word operation refused, coincident with `done` |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath, a 32-bit word half and a 5-bit index. At these values the most-negative constants at both widths can be applied directly. So can the upper-bit junk that word operations must discard, and the unsigned word results whose bit 31 turns into a sign. The exact latencies of 1, 34 and 66 cycles are reached as well. A behavioural model predicts the quotient and the cycle of `done`. The bench compares `done` on every clock of each operation and pokes `start` in mid-iteration.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ITER,
        ST_FINAL,
        ST_RESP
    } qdiv_state_e;
endpackage

// File: rtl/qdiv_prep.sv
module qdiv_prep #(
    parameter int XLEN = 64
) (
    input  logic            is_signed,
    input  logic            is_dword,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] ext_a,
    output logic [XLEN-1:0] mag_a,
    output logic [XLEN-1:0] mag_b,
    output logic            neg_q,
    output logic            div_zero,
    output logic            ovf
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] ext_b;
    logic [XLEN-1:0] min_val;
    logic            sa, sb;

    always_comb begin
        if (is_dword) begin
            ext_a   = opa;
            ext_b   = opb;
            min_val = {1'b1, {(XLEN-1){1'b0}}};
        end else if (is_signed) begin
            ext_a   = {{HALF{opa[HALF-1]}}, opa[HALF-1:0]};
            ext_b   = {{HALF{opb[HALF-1]}}, opb[HALF-1:0]};
            min_val = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};
        end else begin
            ext_a   = {{HALF{1'b0}}, opa[HALF-1:0]};
            ext_b   = {{HALF{1'b0}}, opb[HALF-1:0]};
            min_val = {{(HALF+1){1'b1}}, {(HALF-1){1'b0}}};
        end
        sa       = is_signed & ext_a[XLEN-1];
        sb       = is_signed & ext_b[XLEN-1];
        mag_a    = sa ? (~ext_a + 1'b1) : ext_a;
        mag_b    = sb ? (~ext_b + 1'b1) : ext_b;
        neg_q    = sa ^ sb;
        div_zero = (ext_b == '0);
        ovf      = is_signed && (ext_a == min_val) && (ext_b == {XLEN{1'b1}});
    end
endmodule

// File: rtl/qdiv_iter.sv
module qdiv_iter #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic            word,
    input  logic [XLEN-1:0] dvd,
    input  logic [XLEN-1:0] dvs,
    output logic [XLEN-1:0] quo
);
    localparam int HALF = XLEN / 2;

    logic [XLEN:0]   rem_q;
    logic [XLEN-1:0] quo_q;
    logic [XLEN-1:0] dvs_q;
    logic [XLEN:0]   rem_sh;
    logic [XLEN:0]   diff;

    always_comb begin
        rem_sh = {rem_q[XLEN-1:0], quo_q[XLEN-1]};
        diff   = rem_sh - {1'b0, dvs_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= word ? {dvd[HALF-1:0], {HALF{1'b0}}} : dvd;
            dvs_q <= dvs;
        end else if (step) begin
            rem_q <= diff[XLEN] ? rem_sh : diff;
            quo_q <= {quo_q[XLEN-2:0], ~diff[XLEN]};
        end
    end

    assign quo = quo_q;

    // Each retired bit leaves a partial remainder smaller than the divisor.
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step) && !$past(load) |-> rem_q < {1'b0, dvs_q}) else $error("rem"); // R10
endmodule

// File: rtl/qdiv_post.sv
module qdiv_post #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] quo,
    input  logic            neg,
    input  logic            word,
    output logic [XLEN-1:0] res
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] signed_q;

    always_comb begin
        signed_q = neg ? (~quo + 1'b1) : quo;
        res      = word ? {{HALF{signed_q[HALF-1]}}, signed_q[HALF-1:0]} : signed_q;
    end
endmodule

// File: rtl/qdiv_unit.sv
module qdiv_unit #(
    parameter int XLEN = 64,
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            is_signed,
    input  logic            is_dword,
    input  logic            mode64_en,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [IDXW-1:0] dest,
    output logic [XLEN-1:0] result,
    output logic [IDXW-1:0] result_dest,
    output logic            wr_en,
    output logic            done,
    output logic            illegal
);
    import qdiv_pkg::*;

    localparam int HALF = XLEN / 2;
    localparam int CNTW = $clog2(XLEN);

    qdiv_state_e     state, state_nx;
    logic            sgn_q, dw_q, m64_q;
    logic [XLEN-1:0] a_q, b_q;
    logic [IDXW-1:0] dest_q;
    logic [CNTW-1:0] cnt_q, last_bit;
    logic [XLEN-1:0] res_q;
    logic            wr_q, ill_q;

    logic [XLEN-1:0] ext_a, mag_a, mag_b, quo, fin_res;
    logic            neg_q, div_zero, ovf;
    logic            bad_op, short_path, load, step;

    qdiv_prep #(.XLEN(XLEN)) u_prep (
        .is_signed (sgn_q),
        .is_dword  (dw_q),
        .opa       (a_q),
        .opb       (b_q),
        .ext_a     (ext_a),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .neg_q     (neg_q),
        .div_zero  (div_zero),
        .ovf       (ovf)
    );

    qdiv_iter #(.XLEN(XLEN)) u_iter (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .word  (~dw_q),
        .dvd   (mag_a),
        .dvs   (mag_b),
        .quo   (quo)
    );

    qdiv_post #(.XLEN(XLEN)) u_post (
        .quo  (quo),
        .neg  (neg_q),
        .word (~dw_q),
        .res  (fin_res)
    );

    always_comb begin
        bad_op     = dw_q && !m64_q;
        short_path = bad_op || (dest_q == '0) || div_zero || ovf;
        load       = (state == ST_SETUP) && !short_path;
        step       = (state == ST_ITER);
        last_bit   = dw_q ? CNTW'(XLEN - 1) : CNTW'(HALF - 1);
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SETUP;
            ST_SETUP: state_nx = short_path ? ST_RESP : ST_ITER;
            ST_ITER:  if (cnt_q == last_bit) state_nx = ST_FINAL;
            ST_FINAL: state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Operand capture, counter and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sgn_q  <= 1'b0;
            dw_q   <= 1'b0;
            m64_q  <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
            dest_q <= '0;
            cnt_q  <= '0;
            res_q  <= '0;
            wr_q   <= 1'b0;
            ill_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    sgn_q  <= is_signed;
                    dw_q   <= is_dword;
                    m64_q  <= mode64_en;
                    a_q    <= opa;
                    b_q    <= opb;
                    dest_q <= dest;
                    wr_q   <= 1'b0;
                    ill_q  <= 1'b0;
                end
                ST_SETUP: begin
                    cnt_q <= '0;
                    if (bad_op) begin
                        ill_q <= 1'b1;
                    end else if (dest_q == '0) begin
                        wr_q <= 1'b0;
                    end else if (div_zero) begin
                        res_q <= '0;
                        wr_q  <= 1'b1;
                    end else if (ovf) begin
                        res_q <= ext_a;
                        wr_q  <= 1'b1;
                    end
                end
                ST_ITER:  cnt_q <= cnt_q + 1'b1;
                ST_FINAL: begin
                    res_q <= fin_res;
                    wr_q  <= 1'b1;
                end
                ST_RESP:  ;
                default:  ;
            endcase
        end
    end

    assign done        = (state == ST_RESP);
    assign wr_en       = done && wr_q;
    assign illegal     = done && ill_q;
    assign result      = res_q;
    assign result_dest = dest_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done"); // R11
    AST_WRITE_NONZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done && (result_dest != '0)) else $error("dest"); // R2
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en && dw_q) else $error("ill"); // R9
    AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !dw_q |-> result[XLEN-1:HALF] == {HALF{result[HALF-1]}}) else $error("sext"); // R8
    AST_BUSY_KEEPS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) && (state != ST_RESP) |=> $stable(dest_q)) else $error("busy"); // R11
endmodule

// File: tb/test_qdiv_unit.sv
module test_qdiv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, is_signed = 1'b0, is_dword = 1'b0, mode64_en = 1'b1;
    logic [63:0] opa = '0, opb = '0;
    logic [4:0]  dest = '0;
    logic [63:0] result;
    logic [4:0]  result_dest;
    logic        wr_en, done, illegal;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    qdiv_unit i_qdiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .is_dword(is_dword), .mode64_en(mode64_en), .opa(opa), .opb(opb),
        .dest(dest), .result(result), .result_dest(result_dest),
        .wr_en(wr_en), .done(done), .illegal(illegal)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] sx32(input logic [63:0] v);
        return {{32{v[31]}}, v[31:0]};
    endfunction

    task automatic model(input bit sgn, input bit dw, input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] q, output bit spec);
        longint x, y;
        logic [63:0] ua, ub;
        spec = 1'b0;
        if (dw) begin
            if (b == 0) begin q = 0; spec = 1; end
            else if (sgn && a == 64'h8000_0000_0000_0000 && b == '1) begin q = a; spec = 1; end
            else if (sgn) begin x = a; y = b; q = x / y; end
            else q = a / b;
        end else if (sgn) begin
            x = sx32(a); y = sx32(b);
            if (y == 0) begin q = 0; spec = 1; end
            else if (x == -64'sd2147483648 && y == -1) begin q = x; spec = 1; end
            else q = sx32(x / y);
        end else begin
            ua = {32'h0, a[31:0]}; ub = {32'h0, b[31:0]};
            if (ub == 0) begin q = 0; spec = 1; end
            else q = sx32(ua / ub);
        end
    endtask

    task automatic run_op(input string req, input bit sgn, input bit dw, input bit m64,
                          input logic [63:0] a, input logic [63:0] b, input logic [4:0] d,
                          input bit poke);
        logic [63:0] q;
        bit spec, exp_ill, exp_we;
        int lat;
        model(sgn, dw, a, b, q, spec);
        exp_ill = dw && !m64;
        exp_we  = !exp_ill && d != 0;
        lat = (exp_ill || d == 0 || spec) ? 1 : (dw ? 66 : 34);
        @(negedge clk);
        start = 1; is_signed = sgn; is_dword = dw; mode64_en = m64; opa = a; opb = b; dest = d;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        for (int c = 1; c <= lat + 1; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (poke && c == 2) begin
                start = 1; opa = 64'h77; opb = 64'h1; dest = 5'd9; is_dword = 0;
            end else begin
                start = 0;
            end
            chk({req, " R10 done timing"}, {63'h0, done}, {63'h0, c == lat});
            if (c == lat) begin
                chk({req, " R9 illegal"}, {63'h0, illegal}, {63'h0, exp_ill});
                chk({req, " R1 wr_en"}, {63'h0, wr_en}, {63'h0, exp_we});
                if (exp_we) begin
                    chk({req, " R1 result"}, result, q);
                    chk({req, " R1 dest"}, {59'h0, result_dest}, {59'h0, d});
                end
            end
        end
        start = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 done reset", {63'h0, done}, 64'h0);
        chk("R12 wr_en reset", {63'h0, wr_en}, 64'h0);
        chk("R12 illegal reset", {63'h0, illegal}, 64'h0);
        rst_n = 1;
        // R5 truncation toward zero, all sign combinations
        run_op("R5 +/+", 1, 1, 1, 64'd100, 64'd7, 5'd3, 0);
        run_op("R5 -/+", 1, 1, 1, -64'sd100, 64'd7, 5'd3, 0);
        run_op("R5 +/-", 1, 1, 1, 64'd100, -64'sd7, 5'd4, 0);
        run_op("R5 -/-", 1, 1, 1, -64'sd99, -64'sd7, 5'd31, 0);
        run_op("R1 unsigned dword", 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 5'd5, 0);
        run_op("R4 dword min/-1", 1, 1, 1, 64'h8000_0000_0000_0000, '1, 5'd6, 0);
        run_op("R4 R6 word min/-1", 1, 0, 1, 64'h1234_5678_8000_0000, 64'h0000_0001_FFFF_FFFF, 5'd7, 0);
        run_op("R6 word signed junk", 1, 0, 1, 64'hDEAD_BEEF_FFFF_FFF6, 64'h0000_0001_0000_0003, 5'd8, 0);
        run_op("R6 word min/1", 1, 0, 1, 64'h0000_0000_8000_0000, 64'h1, 5'd8, 0);
        run_op("R7 R8 word unsigned sext", 0, 0, 1, 64'h0123_4567_FFFF_FFFF, 64'hAAAA_0000_0000_0001, 5'd9, 0);
        run_op("R7 word unsigned pos", 0, 0, 1, 64'hFFFF_FFFF_8000_0000, 64'h2, 5'd10, 0);
        run_op("R3 signed dword zero", 1, 1, 1, 64'd55, 64'd0, 5'd11, 0);
        run_op("R3 R7 unsigned word zero", 0, 0, 1, 64'd55, 64'hFFFF_0000_0000_0000, 5'd12, 0);
        run_op("R3 signed word zero", 1, 0, 1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h1_0000_0000, 5'd12, 0);
        run_op("R2 dest zero", 1, 1, 1, 64'd100, 64'd7, 5'd0, 0);
        run_op("R9 illegal dword", 0, 1, 0, 64'd100, 64'd7, 5'd13, 0);
        run_op("R9 word legal in 32-bit mode", 0, 0, 0, 64'd100, 64'd7, 5'd14, 0);
        run_op("R11 busy start ignored", 0, 1, 1, 64'd1000, 64'd10, 5'd15, 1);
        run_op("R11 next op after poke", 1, 0, 1, 64'd81, 64'd9, 5'd16, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule